// File: doc/BRIEF.md
# Masked Two-Level Interrupt Combiner

This block merges a set of locally latched event flags and an eight-bit status byte from a remote device into one level-sensitive interrupt line. Each local event can be enabled separately. The remote status bits pass through their own eight-bit mask and are reduced to a single remote event. That remote event reaches the interrupt only when a dedicated enable bit in the upper local mask byte is set.

Software uses a byte-wide register bus to program the masks, read the event flags, clear them and read the live remote status. Event sources raise flags with single-cycle pulses. A flag stays set until software writes a 1 to its position. The interrupt is computed from the stored flags and masks and passes through one register, so the output is glitch-free.

Top module: `intr_agg_top`

## Requirements
- R1: After a synchronous reset, every mask, every event flag, the captured remote status, `rdata` and `irq_o` are all zero.
- R2: Mask registers read back what was written, with unimplemented bits read as 0. Upper mask at 0x06 implements bits 0 (protocol reset), 1 (transmission error), 3 (position) and 6 (remote enable), giving implemented set 0x4B. Lower mask at 0x07 implements bits 0 (quality warning), 1 (answer), 2 (minimum), 4 (long result) and 5 (short result), giving 0x37. The summary mask at 0x08 implements all eight bits.
- R3: A one-cycle pulse on `evt_hi_set`/`evt_lo_set` sets the flag at the same bit position, restricted to 0x0B (upper) and 0x37 (lower). The flag holds until a bus write of 1 to that bit at 0x04/0x05 clears it. A set in the same cycle as a clear wins.
- R4: Reading 0x04 returns the upper flags, with bit 6 showing the OR of all eight captured remote status bits. Bit 6 cannot be cleared by a write.
- R5: The remote status byte is captured every cycle from `remote_status` and is read at 0x18. Bus writes to 0x18 have no effect.
- R6: `irq_o` rises one clock after any flag is set whose mask bit is also set, and falls one clock after the last such pair is removed.
- R7: When upper-mask bit 6 is 1, any captured remote status bit enabled in the summary mask drives the interrupt. When it is 0, the remote status has no effect on the interrupt.
- R8: A flag whose mask bit is 0 never raises `irq_o`. Reads of unmapped addresses return 0, and writes to them change nothing.
- R9: `rdata` updates on the clock edge at which `rd_en` is sampled high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt_hi_set | input | 8 | Set pulses for upper event flags |
| evt_lo_set | input | 8 | Set pulses for lower event flags |
| remote_status | input | 8 | Remote device status byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench checks that the remote path is gated by the enable bit and not by the unmasked OR shown in event bit 6. A design that used the unmasked OR would raise an interrupt while the summary mask excludes the active status bit. It also drives a set pulse and a clear write in the same cycle. A design with the wrong priority would lose that event. It writes all ones to every mask and writes to the read-only status address. A design that stores unimplemented bits, or lets the status be written, returns different values. Finally, it samples `irq_o` exactly one cycle after each cause. An unregistered or doubly registered path is caught by the cycle offset.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_EVT_HI   = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_EVT_LO   = 8'h05;
  localparam logic [ADDR_W-1:0] ADDR_MASK_HI  = 8'h06;
  localparam logic [ADDR_W-1:0] ADDR_MASK_LO  = 8'h07;
  localparam logic [ADDR_W-1:0] ADDR_SUM_MASK = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_SUM_STAT = 8'h18;

  localparam int BIT_PROTO_RST = 0;
  localparam int BIT_TX_ERR    = 1;
  localparam int BIT_POSITION  = 3;
  localparam int BIT_REMOTE_EN = 6;

  localparam int BIT_QUAL_WARN = 0;
  localparam int BIT_ANSWER    = 1;
  localparam int BIT_MINIMUM   = 2;
  localparam int BIT_LONG_RES  = 4;
  localparam int BIT_SHORT_RES = 5;

  localparam logic [DATA_W-1:0] HI_FLAG_IMPL =
    DATA_W'((1 << BIT_PROTO_RST) | (1 << BIT_TX_ERR) | (1 << BIT_POSITION));
  localparam logic [DATA_W-1:0] HI_MASK_IMPL =
    HI_FLAG_IMPL | DATA_W'(1 << BIT_REMOTE_EN);
  localparam logic [DATA_W-1:0] LO_IMPL =
    DATA_W'((1 << BIT_QUAL_WARN) | (1 << BIT_ANSWER) | (1 << BIT_MINIMUM) |
            (1 << BIT_LONG_RES) | (1 << BIT_SHORT_RES));
  localparam logic [DATA_W-1:0] SUM_IMPL = '1;
endpackage

// File: rtl/intr_evt_flags.sv
module intr_evt_flags #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flag_q
);
  logic [W-1:0] flag_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      flag_d[i] = IMPL[i] & (set_i[i] | (flag_q[i] & ~(clr_en & clr_bits[i])));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  // R3: a flag only rises after a set pulse
  assert_set_needs_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));
  // R3: a flag only falls after a clear write
  assert_hold_until_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(flag_q) & ~flag_q & ~($past(clr_bits) & {W{$past(clr_en)}})) == '0));
endmodule

// File: rtl/intr_mask_regs.sv
module intr_mask_regs #(
  parameter int W = 8,
  parameter logic [W-1:0] HI_IMPL = '1,
  parameter logic [W-1:0] LO_IMPL = '1,
  parameter logic [W-1:0] SM_IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic         wr_sm,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_hi,
  output logic [W-1:0] mask_lo,
  output logic [W-1:0] sum_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi  <= '0;
      mask_lo  <= '0;
      sum_mask <= '0;
    end else begin
      if (wr_hi) mask_hi  <= wdata & HI_IMPL;
      if (wr_lo) mask_lo  <= wdata & LO_IMPL;
      if (wr_sm) sum_mask <= wdata & SM_IMPL;
    end
  end

  // R2: masks change only on a bus write
  assert_mask_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_hi) && !$past(wr_lo) && !$past(wr_sm)) |->
      ($stable(mask_hi) && $stable(mask_lo) && $stable(sum_mask)));
endmodule

// File: rtl/intr_combine.sv
module intr_combine #(
  parameter int W = 8,
  parameter int EN_BIT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_hi,
  input  logic [W-1:0] evt_lo,
  input  logic [W-1:0] mask_hi,
  input  logic [W-1:0] mask_lo,
  input  logic [W-1:0] sum_stat,
  input  logic [W-1:0] sum_mask,
  output logic         irq_o
);
  logic local_hit;
  logic remote_hit;
  logic irq_next;

  always_comb begin
    local_hit  = |(evt_hi & mask_hi) | |(evt_lo & mask_lo);
    remote_hit = mask_hi[EN_BIT] & |(sum_stat & sum_mask);
    irq_next   = local_hit | remote_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irq_next;
  end

  // R8: no enables means no interrupt
  assert_quiet_when_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_hi == '0 && mask_lo == '0) |=> !irq_o);
  // R7: remote path blocked while its enable is low
  assert_remote_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!mask_hi[EN_BIT] && (evt_hi & mask_hi) == '0 && (evt_lo & mask_lo) == '0) |=> !irq_o);
  // R7: enabled remote status raises the interrupt
  assert_remote_fires_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_hi[EN_BIT] && (sum_stat & sum_mask) != '0) |=> irq_o);
  // R6: an enabled local flag raises the interrupt
  assert_local_fires_R6: assert property (@(posedge clk) disable iff (rst)
    ((evt_lo & mask_lo) != '0) |=> irq_o);
endmodule

// File: rtl/intr_agg_top.sv
module intr_agg_top
  import intr_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] evt_hi_set,
  input  logic [DATA_W-1:0] evt_lo_set,
  input  logic [DATA_W-1:0] remote_status,
  output logic              irq_o
);
  logic [DATA_W-1:0] evt_hi_q, evt_lo_q;
  logic [DATA_W-1:0] mask_hi, mask_lo, sum_mask;
  logic [DATA_W-1:0] sum_stat_q;
  logic [DATA_W-1:0] rd_mux;
  logic              clr_hi, clr_lo;

  assign clr_hi = wr_en && (addr == ADDR_EVT_HI);
  assign clr_lo = wr_en && (addr == ADDR_EVT_LO);

  always_ff @(posedge clk) begin
    if (rst) sum_stat_q <= '0;
    else     sum_stat_q <= remote_status;
  end

  intr_evt_flags #(.W(DATA_W), .IMPL(HI_FLAG_IMPL)) u_flags_hi (
    .clk(clk), .rst(rst), .set_i(evt_hi_set),
    .clr_en(clr_hi), .clr_bits(wdata), .flag_q(evt_hi_q));

  intr_evt_flags #(.W(DATA_W), .IMPL(LO_IMPL)) u_flags_lo (
    .clk(clk), .rst(rst), .set_i(evt_lo_set),
    .clr_en(clr_lo), .clr_bits(wdata), .flag_q(evt_lo_q));

  intr_mask_regs #(.W(DATA_W), .HI_IMPL(HI_MASK_IMPL), .LO_IMPL(LO_IMPL),
                   .SM_IMPL(SUM_IMPL)) u_masks (
    .clk(clk), .rst(rst),
    .wr_hi(wr_en && addr == ADDR_MASK_HI),
    .wr_lo(wr_en && addr == ADDR_MASK_LO),
    .wr_sm(wr_en && addr == ADDR_SUM_MASK),
    .wdata(wdata),
    .mask_hi(mask_hi), .mask_lo(mask_lo), .sum_mask(sum_mask));

  intr_combine #(.W(DATA_W), .EN_BIT(BIT_REMOTE_EN)) u_combine (
    .clk(clk), .rst(rst),
    .evt_hi(evt_hi_q), .evt_lo(evt_lo_q),
    .mask_hi(mask_hi), .mask_lo(mask_lo),
    .sum_stat(sum_stat_q), .sum_mask(sum_mask),
    .irq_o(irq_o));

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_EVT_HI: begin
        rd_mux = evt_hi_q;
        rd_mux[BIT_REMOTE_EN] = |sum_stat_q;
      end
      ADDR_EVT_LO:   rd_mux = evt_lo_q;
      ADDR_MASK_HI:  rd_mux = mask_hi;
      ADDR_MASK_LO:  rd_mux = mask_lo;
      ADDR_SUM_MASK: rd_mux = sum_mask;
      ADDR_SUM_STAT: rd_mux = sum_stat_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R9: read data holds without a read strobe
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
  // R2: unimplemented upper mask bits read as zero
  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == ADDR_MASK_HI) |-> ((rdata & ~HI_MASK_IMPL) == '0));
endmodule

// File: tb/tb_intr_agg_top.sv
module tb_intr_agg_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [7:0] evt_hi_set = '0, evt_lo_set = '0, remote_status = '0;
  logic       irq_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_agg_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_hi_set(evt_hi_set),
    .evt_lo_set(evt_lo_set), .remote_status(remote_status), .irq_o(irq_o));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    evt_hi_set = hi; evt_lo_set = lo;
    @(negedge clk);
    evt_hi_set = '0; evt_lo_set = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    bus_read(8'h04, v); check("R1 evt_hi", v, 8'h00);
    bus_read(8'h05, v); check("R1 evt_lo", v, 8'h00);
    bus_read(8'h06, v); check("R1 mask_hi", v, 8'h00);
    bus_read(8'h07, v); check("R1 mask_lo", v, 8'h00);
    bus_read(8'h08, v); check("R1 sum_mask", v, 8'h00);
    bus_read(8'h18, v); check("R1 sum_stat", v, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    bus_write(8'h06, 8'hFF); bus_read(8'h06, v); check("R2 mask_hi", v, 8'h4B);
    bus_write(8'h07, 8'hFF); bus_read(8'h07, v); check("R2 mask_lo", v, 8'h37);
    bus_write(8'h08, 8'hA5); bus_read(8'h08, v); check("R2 sum_mask", v, 8'hA5);
    // R9: rdata holds while rd_en is low
    @(negedge clk); addr = 8'h06;
    @(negedge clk); check("R9 hold", rdata, 8'hA5);
    bus_write(8'h06, 8'h00); bus_write(8'h07, 8'h00); bus_write(8'h08, 8'h00);
    // R8: unmapped address
    bus_write(8'h30, 8'hFF);
    bus_read(8'h30, v); check("R8 unmapped read", v, 8'h00);
    bus_read(8'h07, v); check("R8 unmapped write", v, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] v;
    pulse(8'hFF, 8'hFF);
    bus_read(8'h04, v); check("R3 set hi", v, 8'h0B);
    bus_read(8'h05, v); check("R3 set lo", v, 8'h37);
    bus_read(8'h05, v); check("R3 hold lo", v, 8'h37);
    bus_write(8'h04, 8'h01);
    bus_read(8'h04, v); check("R3 clear hi", v, 8'h0A);
    // R3: set wins over simultaneous clear
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h05; wdata = 8'h10; evt_lo_set = 8'h10;
    @(negedge clk);
    wr_en = 1'b0; evt_lo_set = '0;
    bus_read(8'h05, v); check("R3 set over clear", v, 8'h37);
    bus_write(8'h04, 8'hFF); bus_write(8'h05, 8'hFF);
    bus_read(8'h04, v); check("R3 clear all hi", v, 8'h00);
    bus_read(8'h05, v); check("R3 clear all lo", v, 8'h00);
  endtask

  task automatic t_local_irq();
    bus_write(8'h07, 8'h04);
    pulse(8'h00, 8'h04);
    check("R6 irq latency", {7'd0, irq_o}, 8'h00);
    @(negedge clk); check("R6 irq rise", {7'd0, irq_o}, 8'h01);
    bus_write(8'h05, 8'h04);
    @(negedge clk); check("R6 irq fall", {7'd0, irq_o}, 8'h00);
    pulse(8'h00, 8'h01);
    @(negedge clk); @(negedge clk);
    check("R8 masked event", {7'd0, irq_o}, 8'h00);
    bus_write(8'h06, 8'h08);
    pulse(8'h08, 8'h00);
    @(negedge clk); check("R6 position irq", {7'd0, irq_o}, 8'h01);
    bus_write(8'h06, 8'h00); bus_write(8'h07, 8'h00);
    bus_write(8'h04, 8'hFF); bus_write(8'h05, 8'hFF);
    @(negedge clk); check("R6 irq off", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_remote();
    logic [7:0] v;
    @(negedge clk); remote_status = 8'h20;
    @(negedge clk); @(negedge clk);
    bus_read(8'h18, v); check("R5 status read", v, 8'h20);
    bus_read(8'h04, v); check("R4 summary bit", v, 8'h40);
    bus_write(8'h04, 8'h40);
    bus_read(8'h04, v); check("R4 not clearable", v, 8'h40);
    check("R7 no enable", {7'd0, irq_o}, 8'h00);
    bus_write(8'h08, 8'h20);
    @(negedge clk); check("R7 gate off", {7'd0, irq_o}, 8'h00);
    bus_write(8'h06, 8'h40);
    @(negedge clk); check("R7 gate on", {7'd0, irq_o}, 8'h01);
    bus_write(8'h08, 8'h01);
    @(negedge clk); check("R7 summary masked", {7'd0, irq_o}, 8'h00);
    bus_write(8'h18, 8'hFF);
    bus_read(8'h18, v); check("R5 write ignored", v, 8'h20);
    @(negedge clk); remote_status = 8'h00;
    @(negedge clk); @(negedge clk);
    bus_read(8'h04, v); check("R4 summary clear", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_events();
    t_local_irq();
    t_remote();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule